// File: doc/BRIEF.md
# Selectable-Clock Timer Counter

This block is a free-running 64-bit counter with two counting sources. In core mode it advances by one on every core clock cycle. In external mode it advances by one for each rising edge of a slower timer clock input. That input is asynchronous to the core clock. It is brought into the core domain through a synchroniser and then through an edge detector, which together produce a one-cycle increment enable. The counter itself always runs on the core clock.

Software or surrounding logic can overwrite the count at any time through a synchronous load port. A load wins over an increment in the same cycle.

The mode select is sampled at every core clock edge. When the block is in core mode, the edge detector's history is held so that a level that is already high when the block enters external mode is not counted as a new edge.

Top module: `sel_clk_timer`

## Requirements
- R1: With `clk_sel` = 0 (core mode) and no load, `count` rises by exactly one at every core clock rising edge.
- R2: With `clk_sel` = 1 (external mode), `count` rises by exactly one for each rising edge of `tmr_clk_in`, provided that input stays high for at least one core cycle and low for at least one core cycle, that is, it toggles at no more than half the core frequency.
- R3: In external mode with `tmr_clk_in` held constant (low or high), `count` does not change.
- R4: The counter wraps from all ones to zero without stopping.
- R5: A cycle with `load_en` = 1 makes `count` equal to `load_val` after the next core clock edge.
- R6: While `load_en` = 1, no increment is applied in either mode; `count` equals the loaded value.
- R7: Synchronous reset `rst` = 1 forces `count` to zero and clears the synchroniser and edge detector.
- R8: On entry to external mode while `tmr_clk_in` has been high for at least three core cycles, no count is added until the input goes low and then high again.
- R9: The value of `clk_sel` present at a core clock edge selects the increment source for that edge. Switching to core mode therefore gives one increment per cycle from the first edge after the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 1 | Count source: 0 = core clock, 1 = detected rising edges of `tmr_clk_in` |
| tmr_clk_in | input | 1 | Slow timer clock, asynchronous, at most half the core frequency |
| load_en | input | 1 | Overwrite the count with `load_val` at the next edge |
| load_val | input | CNT_W (64) | Value to load |
| count | output | CNT_W (64) | Current counter value |

## Verification
Faults in this block show up as an accumulated count error. A synchroniser or edge detector that misses or duplicates an edge leaves `count` off by one per pulse, so the bench compares totals after trains of known edge counts. The trains sweep every high and low width from one to four core cycles. In external mode the error becomes visible at most three core cycles after the offending input edge.

A stale edge history shows up as a single extra count right after the switch into external mode. A wrong load priority shows up on the very next cycle as `load_val` plus one. A broken wrap shows up on the cycle after all ones.

// File: rtl/timer_pkg.sv
package timer_pkg;

    localparam int DEF_CNT_W       = 64;
    localparam int DEF_SYNC_STAGES = 2;

    typedef enum logic {
        MODE_CORE = 1'b0,
        MODE_EXT  = 1'b1
    } tmr_mode_e;

    // Rising edge seen when the current level is high and the previous was low.
    function automatic logic rise_of(input logic cur, input logic prev);
        return cur & ~prev;
    endfunction

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int STAGES = timer_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '0;
                else     sh_q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '0;
                else     sh_q <= {sh_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = sh_q[STAGES-1];

    // R7: synchroniser output is low on the first cycle after reset
    assert_sync_reset_R7: assert property (@(posedge clk) rst |=> !dout);
endmodule

// File: rtl/tmr_edge.sv
module tmr_edge
    import timer_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  tmr_mode_e mode,
    input  logic      lvl,
    output logic      pulse
);
    logic prev_q;

    // In core mode the history is held high, so a level already high on
    // entry to external mode is never taken as a new edge.
    always_ff @(posedge clk) begin
        if (rst)                  prev_q <= 1'b1;
        else if (mode == MODE_EXT) prev_q <= lvl;
        else                      prev_q <= 1'b1;
    end

    assign pulse = (mode == MODE_EXT) && rise_of(lvl, prev_q);

    // R2: each detected edge yields a single-cycle enable
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);
    // R8: a core-mode cycle leaves no pending edge for the next cycle
    assert_no_stale_edge_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CORE) |=> !pulse);
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int W = timer_pkg::DEF_CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)          cnt_q <= '0;
        else if (load_en) cnt_q <= load_val;
        else if (inc)     cnt_q <= cnt_q + W'(1);
    end

    assign cnt = cnt_q;

    // R5, R6: load wins and is visible after one edge
    assert_load_R5: assert property (@(posedge clk) disable iff (rst)
        load_en |=> cnt == $past(load_val));
    // R3: no enable, no load -> value holds
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !inc) |=> cnt == $past(cnt));
    // R4: an increment from all ones gives zero
    assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (!load_en && inc && (&cnt)) |=> cnt == '0);
    // R7: reset clears the count
    assert_reset_R7: assert property (@(posedge clk) rst |=> cnt == '0);
endmodule

// File: rtl/sel_clk_timer.sv
module sel_clk_timer
    import timer_pkg::*;
#(
    parameter int CNT_W       = DEF_CNT_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_sel,
    input  logic             tmr_clk_in,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count
);
    tmr_mode_e mode;
    logic      lvl_sync;
    logic      ext_pulse;
    logic      inc_en;

    assign mode = tmr_mode_e'(clk_sel);

    tmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (tmr_clk_in),
        .dout (lvl_sync)
    );

    tmr_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode),
        .lvl   (lvl_sync),
        .pulse (ext_pulse)
    );

    assign inc_en = (mode == MODE_CORE) | ext_pulse;

    tmr_count #(.W(CNT_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .load_en  (load_en),
        .load_val (load_val),
        .inc      (inc_en),
        .cnt      (count)
    );

    // R1, R9: core mode steps by one at every edge
    assert_core_step_R1: assert property (@(posedge clk) disable iff (rst)
        (!clk_sel && !load_en) |=> count == $past(count) + CNT_W'(1));
    // R2: external mode never steps by more than one
    assert_ext_step_R2: assert property (@(posedge clk) disable iff (rst)
        (clk_sel && !load_en) |=>
            (count == $past(count)) || (count == $past(count) + CNT_W'(1)));
endmodule

// File: tb/sel_clk_timer_tb.sv
module sel_clk_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst;
    logic         clk_sel;
    logic         tmr_clk_in;
    logic         load_en;
    logic [W-1:0] load_val;
    logic [W-1:0] count;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sel_clk_timer u_dut (
        .clk        (clk),
        .rst        (rst),
        .clk_sel    (clk_sel),
        .tmr_clk_in (tmr_clk_in),
        .load_en    (load_en),
        .load_val   (load_val),
        .count      (count)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_load(input logic [W-1:0] v);
        load_en  = 1'b1;
        load_val = v;
        step(1);
        load_en  = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [W-1:0] c0;
        rst = 1'b1; clk_sel = 1'b0; tmr_clk_in = 1'b0;
        load_en = 1'b0; load_val = '0;
        step(3);
        chk("R7 reset value", count, '0);
        rst = 1'b0;

        // R1: core mode counts every cycle
        c0 = count;
        step(37);
        chk("R1 core mode 37 cycles", count, c0 + 37);

        // R5 load, then R1 resumes
        do_load(64'h1234_5678_9abc_def0);
        chk("R5 load value", count, 64'h1234_5678_9abc_def0);
        step(1);
        chk("R1 after load", count, 64'h1234_5678_9abc_def1);

        // R6: held load suppresses increment
        load_en = 1'b1; load_val = 64'd500;
        step(3);
        chk("R6 load priority core", count, 64'd500);
        load_en = 1'b0;

        // R4: wrap
        do_load(64'hFFFF_FFFF_FFFF_FFFD);
        step(5);
        chk("R4 wrap to zero", count, 64'd2);

        // R3: external mode, static low then static high
        clk_sel = 1'b1; tmr_clk_in = 1'b0;
        step(4);
        c0 = count;
        step(10);
        chk("R3 static low", count, c0);
        tmr_clk_in = 1'b1;
        step(4);
        c0 = count;
        step(10);
        chk("R3 static high", count, c0);
        tmr_clk_in = 1'b0;
        step(4);

        // R2: sweep high/low widths of 1..4 core cycles
        for (int hi = 1; hi <= 4; hi++) begin
            for (int lo = 1; lo <= 4; lo++) begin
                c0 = count;
                for (int k = 0; k < 5; k++) begin
                    tmr_clk_in = 1'b1; step(hi);
                    tmr_clk_in = 1'b0; step(lo);
                end
                step(4);
                chk($sformatf("R2 edges hi=%0d lo=%0d", hi, lo), count, c0 + 5);
            end
        end

        // R6: load during external edges
        load_en = 1'b1; load_val = 64'd77;
        for (int k = 0; k < 3; k++) begin
            tmr_clk_in = 1'b1; step(1);
            tmr_clk_in = 1'b0; step(1);
        end
        step(3);
        chk("R6 load priority ext", count, 64'd77);
        load_en = 1'b0;
        step(2);
        chk("R6 no late edge after load", count, 64'd77);

        // R9: switch to core mode counts from the first edge
        c0 = count;
        clk_sel = 1'b0;
        step(3);
        chk("R9 switch to core", count, c0 + 3);

        // R8: enter external mode with input long high
        tmr_clk_in = 1'b1;
        step(5);
        c0 = count;
        clk_sel = 1'b1;
        step(6);
        chk("R8 no stale edge", count, c0);
        tmr_clk_in = 1'b0; step(3);
        tmr_clk_in = 1'b1; step(3);
        tmr_clk_in = 1'b0; step(3);
        chk("R8 fresh edge counted", count, c0 + 1);

        // R7: reset mid-run
        clk_sel = 1'b0;
        do_load(64'hDEAD_BEEF);
        rst = 1'b1;
        step(1);
        chk("R7 mid-run reset", count, '0);
        rst = 1'b0;
        step(4);
        chk("R7 count restarts", count, 64'd4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule